// File: doc/BRIEF.md
# NAND Flash Command Interface Device Model

This block models the device side of an 8-bit NAND flash command interface, clocked by a system clock that oversamples the strobe pins. Bytes on the input bus are latched when the write strobe rises while the chip is selected. The command-latch and address-latch qualifiers decide whether the byte is a command or an address. The block keeps a column pointer whose upper bits come from three area-select commands. It counts address cycles and returns identification bytes, a status byte or page-register data on each read strobe.

The cell array is replaced by a computed page pattern, byte = (column mod 256) XOR row byte, and a page fetch is emulated by a parameterised busy time on the ready output. It is meant for testing host-side flash controllers against a synthesizable device model.

Top module: `nand_cmd_model`

## Requirements
- R1: A bus byte is latched on a rising edge of `we_n` seen while `ce_n` is low: it is a command when `cle`=1 and `ale`=0, and an address when `ale`=1 and `cle`=0. A strobe with `ce_n` high has no effect.
- R2: Command 00h selects area A (base column 0), 01h area B (base 256) and 50h area C (base 512). The first address byte after any of these gives the start column: base + byte for A and B, and base + byte[3:0] for C.
- R3: The read sequence is one of the area commands followed by four address cycles; the second address byte is the row byte. On the clock after the fourth address cycle `rb` goes low, and it stays low for exactly BUSY_CYCLES clocks.
- R4: After the read busy time, each read strobe returns (column mod 256) XOR row byte. Each rising edge of `re_n` advances the column by one.
- R5: The column never exceeds 527. Advancing from column 527 returns it to the base of the selected area.
- R6: Command 90h followed by one address cycle makes successive read strobes return ECh, 76h, A5h, C0h, then repeat from ECh.
- R7: Command 70h makes read strobes return the status byte: bit 7 = `wp_n`, bit 6 = ready (1 when not busy), bit 0 = failure (always 0 here), and the other bits 0.
- R8: Command FFh is accepted even while busy. It ends any busy period so that `rb` is high on the next clock, and it clears the pending command sequence. The status then reads C0h with `wp_n` high and 40h with `wp_n` low.
- R9: While busy, every command other than 70h and FFh is ignored, and so is every address cycle. A read in progress then still returns page data from its own start column.
- R10: `io_oe` is 1 only while `ce_n` and `re_n` are both low, and `io_out` is 00h whenever `io_oe` is 0.
- R11: After reset `rb` is high and the status byte with `wp_n` high is C0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the strobe pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| we_n | input | 1 | Write strobe; byte latched on its rising edge |
| re_n | input | 1 | Read strobe; data valid while low, column advances on rise |
| wp_n | input | 1 | Write-protect pin; high means not protected |
| io_in | input | 8 | Command, address or data byte from the host |
| io_out | output | 8 | Byte returned to the host |
| io_oe | output | 1 | Output enable for `io_out` |
| rb | output | 1 | Ready (1) or busy (0) |

## Verification
A wrong column or pointer state shows up at the first read strobe after the busy period, as a byte that departs from the XOR pattern. An off-by-one in column advance or wrap shows up at the very next strobe, or at the strobe that crosses column 527. A busy counter loaded with the wrong length moves the rising edge of `rb` away from the exact clock count. A command wrongly accepted while busy appears as identification or status bytes where page data should be.

// File: rtl/nand_if_pkg.sv
`timescale 1ns/1ps
package nand_if_pkg;
  localparam int COL_W = 10;

  localparam logic [7:0] CMD_AREA_A = 8'h00;
  localparam logic [7:0] CMD_AREA_B = 8'h01;
  localparam logic [7:0] CMD_AREA_C = 8'h50;
  localparam logic [7:0] CMD_ID     = 8'h90;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_RESET  = 8'hFF;

  typedef enum logic [1:0] {PTR_A, PTR_B, PTR_C} ptr_e;
  typedef enum logic [1:0] {OUT_IDLE, OUT_DATA, OUT_ID, OUT_STAT} out_e;
  typedef enum logic [1:0] {SEQ_NONE, SEQ_READ, SEQ_ID} seq_e;

  function automatic logic [COL_W-1:0] area_base(input ptr_e p);
    case (p)
      PTR_B:   area_base = COL_W'(256);
      PTR_C:   area_base = COL_W'(512);
      default: area_base = '0;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] start_col(input ptr_e p, input logic [7:0] b);
    if (p == PTR_C) start_col = area_base(p) + COL_W'(b[3:0]);
    else            start_col = area_base(p) + COL_W'(b);
  endfunction

  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input ptr_e p,
                                                input logic [COL_W-1:0] last);
    if (c >= last) step_col = area_base(p);
    else           step_col = c + COL_W'(1);
  endfunction

  function automatic logic [7:0] page_byte(input logic [COL_W-1:0] c, input logic [7:0] row);
    page_byte = c[7:0] ^ row;
  endfunction

  function automatic logic [7:0] id_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    id_byte = 8'hEC;
      2'd1:    id_byte = 8'h76;
      2'd2:    id_byte = 8'hA5;
      default: id_byte = 8'hC0;
    endcase
  endfunction
endpackage

// File: rtl/nand_strobe_edge.sv
`timescale 1ns/1ps
module nand_strobe_edge #(
  parameter int N_STB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic [N_STB-1:0] stb_n,
  output logic [N_STB-1:0] rise
);
  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= stb_n[g];
    end
    assign rise[g] = ~ce_n & ~prev_q & stb_n[g];
  end
endmodule

// File: rtl/nand_busy_timer.sv
`timescale 1ns/1ps
module nand_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (abort)          cnt_q <= '0;
    else if (start)          cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy = (cnt_q != '0);

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> busy); // R3
  AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R8
endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
  import nand_if_pkg::*;
#(
  parameter int PAGE_BYTES = 528
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_rise,
  input  logic             re_rise,
  input  logic             cle,
  input  logic             ale,
  input  logic [7:0]       io_in,
  input  logic             busy,
  output logic             start_busy,
  output logic             abort,
  output ptr_e             ptr,
  output logic [COL_W-1:0] col,
  output logic [7:0]       row,
  output logic [1:0]       id_idx,
  output out_e             out_mode
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  seq_e       seq_q;
  logic [1:0] addr_cnt_q;
  logic       cmd_stb, addr_stb, cmd_ok, addr_ok, cmd_bypass;

  assign cmd_stb    = we_rise & cle & ~ale;
  assign addr_stb   = we_rise & ale & ~cle;
  assign cmd_bypass = (io_in == CMD_STAT) || (io_in == CMD_RESET);
  assign cmd_ok     = cmd_stb & (~busy | cmd_bypass);
  assign addr_ok    = addr_stb & ~busy;
  assign abort      = cmd_ok & (io_in == CMD_RESET);
  assign start_busy = addr_ok & (seq_q == SEQ_READ) & (addr_cnt_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= PTR_A;
      seq_q      <= SEQ_NONE;
      addr_cnt_q <= '0;
      col        <= '0;
      row        <= '0;
      id_idx     <= '0;
      out_mode   <= OUT_IDLE;
    end else if (cmd_ok) begin
      case (io_in)
        CMD_AREA_A: begin ptr <= PTR_A; seq_q <= SEQ_READ; addr_cnt_q <= '0; end
        CMD_AREA_B: begin ptr <= PTR_B; seq_q <= SEQ_READ; addr_cnt_q <= '0; end
        CMD_AREA_C: begin ptr <= PTR_C; seq_q <= SEQ_READ; addr_cnt_q <= '0; end
        CMD_ID:     begin seq_q <= SEQ_ID; addr_cnt_q <= '0; end
        CMD_STAT:   out_mode <= OUT_STAT;
        CMD_RESET: begin
          ptr        <= PTR_A;
          seq_q      <= SEQ_NONE;
          addr_cnt_q <= '0;
          out_mode   <= OUT_IDLE;
        end
        default: ;
      endcase
    end else if (addr_ok) begin
      case (seq_q)
        SEQ_READ: begin
          addr_cnt_q <= addr_cnt_q + 2'd1;
          if (addr_cnt_q == 2'd0) col <= start_col(ptr, io_in);
          if (addr_cnt_q == 2'd1) row <= io_in;
          if (addr_cnt_q == 2'd3) begin
            out_mode <= OUT_DATA;
            seq_q    <= SEQ_NONE;
          end
        end
        SEQ_ID: begin
          id_idx   <= '0;
          out_mode <= OUT_ID;
          seq_q    <= SEQ_NONE;
        end
        default: ;
      endcase
    end else if (re_rise && !busy) begin
      if (out_mode == OUT_DATA)    col    <= step_col(col, ptr, LAST_COL);
      else if (out_mode == OUT_ID) id_idx <= id_idx + 2'd1;
    end
  end

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col <= LAST_COL); // R5
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (re_rise && !we_rise && !busy && out_mode == OUT_DATA && col == LAST_COL)
      |=> col == area_base(ptr)); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_stb && !cmd_bypass) |=> ($stable(ptr) && $stable(out_mode))); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (out_mode == OUT_IDLE && seq_q == SEQ_NONE)); // R8
endmodule

// File: rtl/nand_cmd_model.sv
`timescale 1ns/1ps
module nand_cmd_model
  import nand_if_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int BUSY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb
);
  logic [1:0]       rise;
  logic             we_rise, re_rise, busy, start_busy, abort;
  ptr_e             ptr;
  logic [COL_W-1:0] col;
  logic [7:0]       row, status_byte, sel_byte;
  logic [1:0]       id_idx;
  out_e             out_mode;

  nand_strobe_edge #(.N_STB(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n),
    .stb_n({re_n, we_n}), .rise(rise)
  );
  assign we_rise = rise[0];
  assign re_rise = rise[1];

  nand_cmd_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .we_rise(we_rise), .re_rise(re_rise),
    .cle(cle), .ale(ale), .io_in(io_in), .busy(busy),
    .start_busy(start_busy), .abort(abort), .ptr(ptr), .col(col),
    .row(row), .id_idx(id_idx), .out_mode(out_mode)
  );

  nand_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start_busy), .abort(abort), .busy(busy)
  );

  assign status_byte = {wp_n, ~busy, 5'b00000, 1'b0};
  assign rb          = ~busy;

  always_comb begin
    case (out_mode)
      OUT_DATA: sel_byte = page_byte(col, row);
      OUT_ID:   sel_byte = id_byte(id_idx);
      OUT_STAT: sel_byte = status_byte;
      default:  sel_byte = 8'h00;
    endcase
  end

  assign io_oe  = ~ce_n & ~re_n;
  assign io_out = io_oe ? sel_byte : 8'h00;

  AST_STAT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && out_mode == OUT_STAT) |-> (io_out[6] == rb)); // R7
  AST_NO_REPTR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort) |=> $stable(ptr)); // R9
endmodule

// File: tb/sim_nand_cmd_model.sv
`timescale 1ns/1ps
module sim_nand_cmd_model;
  localparam int BUSY = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rb;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  nand_cmd_model #(.PAGE_BYTES(528), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rb(rb)
  );

  // {command, first address byte, row byte, reads}
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'h05, 8'h33, 8'd3},
    {8'h01, 8'h0A, 8'h12, 8'd3},
    {8'h50, 8'h03, 8'hA0, 8'd3},
    {8'h00, 8'hFF, 8'h01, 8'd3},
    {8'h01, 8'hFF, 8'h5C, 8'd3},
    {8'h50, 8'h1F, 8'h77, 8'd3}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b, input logic sel_n = 1'b0);
    @(negedge clk); ce_n = sel_n; cle = c; ale = a; io_in = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = io_out;
    chk("R10 oe while reading", int'(io_oe), 1);
    re_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rb && n < 1000) begin @(negedge clk); n++; end
  endtask

  function automatic int base_of(input logic [7:0] cmd);
    if (cmd == 8'h01) return 256;
    if (cmd == 8'h50) return 512;
    return 0;
  endfunction

  function automatic int first_col(input logic [7:0] cmd, input logic [7:0] b);
    return base_of(cmd) + ((cmd == 8'h50) ? (b % 16) : b);
  endfunction

  function automatic int adv(input int c, input logic [7:0] cmd);
    return (c == 527) ? base_of(cmd) : c + 1;
  endfunction

  function automatic int exp_byte(input int c, input logic [7:0] r);
    return (c % 256) ^ r;
  endfunction

  task automatic start_read(input logic [7:0] cmd, input logic [7:0] b, input logic [7:0] r);
    wr(1, 0, cmd);
    wr(0, 1, b);
    wr(0, 1, r);
    wr(0, 1, 8'h00);
    wr(0, 1, 8'h00);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int n, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rb after reset", int'(rb), 1);
    chk("R10 oe idle", int'(io_oe), 0);
    chk("R10 out idle", int'(io_out), 0);
    wr(1, 0, 8'h70);
    rd(v); chk("R11 status after reset", v, 8'hC0);

    // vector walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic [7:0] cmd, b, r, nr;
      {cmd, b, r, nr} = VEC[i];
      start_read(cmd, b, r);
      chk("R3 busy after 4th address", int'(rb), 0);
      wait_ready(n);
      chk("R3 busy length", n, BUSY);
      c = first_col(cmd, b);
      for (int k = 0; k < int'(nr); k++) begin
        rd(v); chk("R2 R4 R5 page byte", v, exp_byte(c, r));
        c = adv(c, cmd);
      end
    end

    // R5 long wrap in area A
    start_read(8'h00, 8'd250, 8'h44);
    wait_ready(n);
    c = 250;
    for (int k = 0; k < 282; k++) begin
      rd(v); chk("R5 wrap area A", v, exp_byte(c, 8'h44));
      c = adv(c, 8'h00);
    end

    // R6 identification
    wr(1, 0, 8'h90);
    wr(0, 1, 8'h00);
    rd(v); chk("R6 id0", v, 8'hEC);
    rd(v); chk("R6 id1", v, 8'h76);
    rd(v); chk("R6 id2", v, 8'hA5);
    rd(v); chk("R6 id3", v, 8'hC0);
    rd(v); chk("R6 id repeat", v, 8'hEC);

    // R7 status while busy and after
    start_read(8'h00, 8'h10, 8'h00);
    wr(1, 0, 8'h70);
    rd(v); chk("R7 status busy", v, 8'h80);
    wait_ready(n);
    rd(v); chk("R7 status ready", v, 8'hC0);

    // R1 strobe with chip deselected ignored
    wr(1, 0, 8'h90, 1'b1);
    rd(v); chk("R1 deselected cmd ignored", v, 8'hC0);

    // R9 commands and addresses ignored while busy
    start_read(8'h00, 8'h20, 8'h0F);
    wr(1, 0, 8'h90);
    wr(0, 1, 8'h00);
    wr(1, 0, 8'h01);
    wait_ready(n);
    rd(v); chk("R9 data kept", v, exp_byte(32, 8'h0F));
    rd(v); chk("R9 data next", v, exp_byte(33, 8'h0F));

    // R8 reset aborts busy
    start_read(8'h01, 8'h00, 8'h00);
    chk("R8 busy before reset", int'(rb), 0);
    wr(1, 0, 8'hFF);
    chk("R8 ready after reset", int'(rb), 1);
    wr(1, 0, 8'h70);
    rd(v); chk("R8 status wp high", v, 8'hC0);
    wp_n = 1'b0;
    wr(1, 0, 8'hFF);
    rd(v); chk("R8 output idle after reset", v, 8'h00);
    wr(1, 0, 8'h70);
    rd(v); chk("R8 status wp low", v, 8'h40);
    wp_n = 1'b1;

    @(negedge clk);
    chk("R10 oe released", int'(io_oe), 0);
    chk("R10 out released", int'(io_out), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule